// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator CPU. Each cycle it takes the accumulator, a second operand and a 4-bit operation select. Combinational logic produces the 8-bit result and the next zero (Z), subtract (N), half-carry (H) and carry (C) flags. A 4-bit flag register stores the flags. It loads when the flag write strobe is high and supplies the incoming carry and the decimal-adjust state for later operations.

The accumulator itself lives outside the block. The block raises a write request when the caller enables a write and the selected operation produces a new accumulator value. Compare, the two carry-flag operations and the reserved codes never request a write. Instruction decode, memory traffic and 16-bit arithmetic belong to other blocks.

Top module: `alu8_acc_top`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry) return (acc + opnd + cin) mod 256, with cin taken from the registered C flag for op 1 and 0 for op 0. Z is set when the result is zero, N is cleared, H is the carry out of bit 3 and C is the carry out of bit 7.
- R2: Op 2 (subtract) and op 3 (subtract with borrow) return (acc − opnd − cin) mod 256, with cin taken from the registered C flag for op 3 and 0 for op 2. Z is set when the result is zero and N is set. H is set when the low nibble of acc is below the low nibble of opnd plus cin. C is set when acc is below opnd + cin.
- R3: Op 7 (compare) produces the same flags as op 2 and never requests an accumulator write.
- R4: Op 4 (and), op 5 (xor) and op 6 (or) return the bitwise result and set Z when it is zero. All three clear N and C. H is set for and and cleared for xor and or.
- R5: Op 8 (increment) and op 9 (decrement) wrap modulo 256 and set Z when the result is zero. Increment clears N and sets H when the result's low nibble is 0x0. Decrement sets N and sets H when the result's low nibble is 0xF. C keeps its registered value for both.
- R6: Op 11 (complement) returns acc XOR 0xFF, sets N and H, and keeps Z and C.
- R7: Op 10 (decimal adjust) uses a correction of 0x06 and/or 0x60 and leaves N unchanged. When N is clear, 0x06 applies if H is set or acc[3:0] > 9, 0x60 applies if C is set or acc > 0x99, and the correction is added. When N is set, 0x06 applies if H is set, 0x60 applies if C is set, and the correction is subtracted. C is set when the 0x60 part applies and otherwise keeps its value. H is cleared and Z follows the result.
- R8: Op 12 inverts C and op 13 sets C. Both clear N and H, keep Z, return acc unchanged and request no write.
- R9: Ops 14 and 15 are reserved. They return acc, leave all flags at their registered values and request no write.
- R10: acc_wr_o is high only when wr_en_i is high and the op is one of 0–6 or 8–11.
- R11: flags_o holds the registered flags as [3]=Z, [2]=N, [1]=H, [0]=C. On a rising clock edge it loads flags_nxt_o when flag_we_i is high and otherwise holds its value.
- R12: A synchronous reset clears flags_o to 0000 and takes priority over flag_we_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset of the flag register |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| op_i | input | 4 | Operation select |
| wr_en_i | input | 1 | Caller permits an accumulator write this cycle |
| flag_we_i | input | 1 | Load the computed flags at the next edge |
| result_o | output | 8 | Combinational result |
| acc_wr_o | output | 1 | Accumulator write request |
| flags_nxt_o | output | 4 | Flags the current operation would produce |
| flags_o | output | 4 | Registered flags {Z,N,H,C} |

## Verification
The hardest case to reach is decimal adjust under each of the eight N/H/C combinations. The flag register can only be loaded with the result of a real operation, so there is no direct way to set it. Before each decimal-adjust sweep, the bench searches its own arithmetic model for an add, subtract or logic operation that yields the wanted N/H/C state. It clocks that operation in with the flag strobe and then runs all 256 accumulator values against that state. The carry-in paths are covered the same way: a set-carry or invert-carry operation is clocked in before the operand sweeps.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 4;
    localparam int FLW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_XOR  = 4'd5,
        OP_OR   = 4'd6,
        OP_CP   = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_DAA  = 4'd10,
        OP_CPL  = 4'd11,
        OP_CCF  = 4'd12,
        OP_SCF  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        flags_t        fl;
        logic          wr;
    } alu_out_t;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          half_o,
    output logic          carry_o
);
    logic [DW:0] full_w;
    logic [NW:0] low_w;

    always_comb begin
        if (sub_i) begin
            full_w = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin_i};
            low_w  = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - {{NW{1'b0}}, cin_i};
        end else begin
            full_w = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
            low_w  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin_i};
        end
        sum_o   = full_w[DW-1:0];
        half_o  = low_w[NW];
        carry_o = full_w[DW];
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_CPL:  res_o = ~a_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_daa.sv
`timescale 1ns/1ps
module alu8_daa
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  flags_t        fl_i,
    output logic [DW-1:0] res_o,
    output logic          carry_o
);
    localparam logic [NW-1:0] NIB_FIX = NW'(6);
    localparam logic [NW-1:0] NIB_MAX = NW'(9);
    localparam logic [DW-1:0] BYTE_MAX = {NIB_MAX, NIB_MAX};

    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] corr;

    always_comb begin
        if (fl_i.n) begin
            lo_fix = fl_i.h;
            hi_fix = fl_i.c;
        end else begin
            lo_fix = fl_i.h | (a_i[NW-1:0] > NIB_MAX);
            hi_fix = fl_i.c | (a_i > BYTE_MAX);
        end
        corr    = {(hi_fix ? NIB_FIX : '0), (lo_fix ? NIB_FIX : '0)};
        res_o   = fl_i.n ? (a_i - corr) : (a_i + corr);
        carry_o = hi_fix;
    end
endmodule

// File: rtl/alu8_acc_top.sv
`timescale 1ns/1ps
module alu8_acc_top
    import alu8_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  opnd_i,
    input  logic [OPW-1:0] op_i,
    input  logic           wr_en_i,
    input  logic           flag_we_i,
    output logic [DW-1:0]  result_o,
    output logic           acc_wr_o,
    output logic [FLW-1:0] flags_nxt_o,
    output logic [FLW-1:0] flags_o
);
    alu_op_e  op;
    flags_t   flags_d, flags_q;
    alu_out_t nxt;

    logic          as_sub, as_cin;
    logic [DW-1:0] as_sum;
    logic          as_h, as_c;
    logic [DW-1:0] id_sum;
    logic          id_h, id_c;
    logic [DW-1:0] lg_res;
    logic [DW-1:0] da_res;
    logic          da_c;

    assign op     = alu_op_e'(op_i);
    assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
    assign as_cin = flags_q.c & ((op == OP_ADC) || (op == OP_SBC));

    alu8_addsub main_as_i (
        .a_i(acc_i), .b_i(opnd_i), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .half_o(as_h), .carry_o(as_c)
    );

    alu8_addsub step_as_i (
        .a_i(acc_i), .b_i(DW'(1)), .cin_i(1'b0), .sub_i(op == OP_DEC),
        .sum_o(id_sum), .half_o(id_h), .carry_o(id_c)
    );

    alu8_logic logic_i (
        .op_i(op), .a_i(acc_i), .b_i(opnd_i), .res_o(lg_res)
    );

    alu8_daa daa_i (
        .a_i(acc_i), .fl_i(flags_q), .res_o(da_res), .carry_o(da_c)
    );

    always_comb begin
        nxt.res = acc_i;
        nxt.fl  = flags_q;
        nxt.wr  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP: begin
                nxt.res  = as_sum;
                nxt.fl.z = (as_sum == '0);
                nxt.fl.n = as_sub;
                nxt.fl.h = as_h;
                nxt.fl.c = as_c;
                nxt.wr   = (op != OP_CP);
            end
            OP_AND, OP_XOR, OP_OR: begin
                nxt.res  = lg_res;
                nxt.fl.z = (lg_res == '0);
                nxt.fl.n = 1'b0;
                nxt.fl.h = (op == OP_AND);
                nxt.fl.c = 1'b0;
                nxt.wr   = 1'b1;
            end
            OP_INC, OP_DEC: begin
                nxt.res  = id_sum;
                nxt.fl.z = (id_sum == '0);
                nxt.fl.n = (op == OP_DEC);
                nxt.fl.h = (op == OP_DEC) ? (id_sum[NW-1:0] == '1) : (id_sum[NW-1:0] == '0);
                nxt.wr   = 1'b1;
            end
            OP_DAA: begin
                nxt.res  = da_res;
                nxt.fl.z = (da_res == '0);
                nxt.fl.h = 1'b0;
                nxt.fl.c = da_c;
                nxt.wr   = 1'b1;
            end
            OP_CPL: begin
                nxt.res  = lg_res;
                nxt.fl.n = 1'b1;
                nxt.fl.h = 1'b1;
                nxt.wr   = 1'b1;
            end
            OP_CCF, OP_SCF: begin
                nxt.fl.n = 1'b0;
                nxt.fl.h = 1'b0;
                nxt.fl.c = (op == OP_SCF) ? 1'b1 : ~flags_q.c;
            end
            default: begin
                nxt.res = acc_i;
            end
        endcase
        flags_d = flag_we_i ? nxt.fl : flags_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) flags_q <= '0;
        else       flags_q <= flags_d;
    end

    assign result_o    = nxt.res;
    assign acc_wr_o    = nxt.wr & wr_en_i;
    assign flags_nxt_o = nxt.fl;
    assign flags_o     = flags_q;

    // R11
    flag_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        flag_we_i |=> (flags_o == $past(flags_nxt_o)));

    // R11
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !flag_we_i |=> $stable(flags_o));

    // R3
    cp_nowrite_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_CP) |-> !acc_wr_o);

    // R5
    incdec_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((op_i == OP_INC) || (op_i == OP_DEC)) |-> (flags_nxt_o[0] == flags_o[0]));

    // R8
    carry_op_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((op_i == OP_CCF) || (op_i == OP_SCF)) |->
            ((flags_nxt_o[2:1] == 2'b00) && (flags_nxt_o[3] == flags_o[3]) && (result_o == acc_i)));
endmodule

// File: tb/alu8_acc_top_tb.sv
`timescale 1ns/1ps
module alu8_acc_top_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [3:0] op_i = '0;
    logic       wr_en_i = 1'b1;
    logic       flag_we_i = 1'b0;
    logic [7:0] result_o;
    logic       acc_wr_o;
    logic [3:0] flags_nxt_o;
    logic [3:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] cur_fl = 4'b0000;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    alu8_acc_top dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
        .wr_en_i(wr_en_i), .flag_we_i(flag_we_i), .result_o(result_o),
        .acc_wr_o(acc_wr_o), .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
    );

    // returns {wr, Z, N, H, C, result}
    function automatic logic [12:0] model(int op, int a, int b, logic [3:0] f);
        int r, t, cin, corr;
        logic z, n, h, c, w;
        z = f[3]; n = f[2]; h = f[1]; c = f[0]; r = a; w = 1'b0;
        case (op)
            0, 1: begin
                cin = (op == 1) ? int'(c) : 0;
                t = a + b + cin; r = t % 256;
                h = ((a % 16) + (b % 16) + cin) > 15; c = t > 255;
                n = 0; z = (r == 0); w = 1;
            end
            2, 3, 7: begin
                cin = (op == 3) ? int'(c) : 0;
                t = a - b - cin; r = (t + 512) % 256;
                h = (a % 16) < ((b % 16) + cin); c = t < 0;
                n = 1; z = (r == 0); w = (op != 7);
            end
            4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; w = 1; end
            5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; w = 1; end
            8: begin r = (a + 1) % 256; z = (r == 0); n = 0; h = (r % 16) == 0; w = 1; end
            9: begin r = (a + 255) % 256; z = (r == 0); n = 1; h = (r % 16) == 15; w = 1; end
            10: begin
                corr = 0;
                if (!n) begin
                    if (h || (a % 16) > 9) corr += 6;
                    if (c || a > 153) begin corr += 96; c = 1; end
                    r = (a + corr) % 256;
                end else begin
                    if (h) corr += 6;
                    if (c) corr += 96;
                    r = (a - corr + 256) % 256;
                end
                h = 0; z = (r == 0); w = 1;
            end
            11: begin r = 255 - a; n = 1; h = 1; w = 1; end
            12: begin n = 0; h = 0; c = !c; end
            13: begin n = 0; h = 0; c = 1; end
            default: ;
        endcase
        return {w, z, n, h, c, 8'(r)};
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0, 1:   return "R1";
            2, 3:   return "R2";
            7:      return "R3";
            4, 5, 6: return "R4";
            8, 9:   return "R5";
            11:     return "R6";
            10:     return "R7";
            12, 13: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_eq(string tag, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (op=%0d a=%h b=%h)", tag, act, exp, op_i, acc_i, opnd_i);
        end
    endtask

    task automatic eval(int op, int a, int b, string tag);
        logic [12:0] e;
        op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b);
        #1;
        e = model(op, a, b, cur_fl);
        e[12] = e[12] & wr_en_i;
        check_eq(tag, {acc_wr_o, flags_nxt_o, result_o}, e);
    endtask

    task automatic clock_in(int op, int a, int b);
        logic [12:0] e;
        @(negedge clk_i);
        op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b); flag_we_i = 1'b1;
        e = model(op, a, b, cur_fl);
        @(negedge clk_i);
        flag_we_i = 1'b0;
        cur_fl = e[11:8];
        check_eq("R11", {9'd0, flags_o}, {9'd0, cur_fl});
    endtask

    task automatic load_nhc(logic [2:0] tgt);
        int ops[6] = '{0, 2, 4, 5, 1, 3};
        int fo, fa, fb;
        logic [12:0] e;
        bit found = 0;
        fo = 0; fa = 0; fb = 0;
        foreach (ops[k]) begin
            for (int a = 0; a < 256 && !found; a++) begin
                for (int b = 0; b < 256 && !found; b++) begin
                    e = model(ops[k], a, b, cur_fl);
                    if (e[10:8] == tgt) begin found = 1; fo = ops[k]; fa = a; fb = b; end
                end
            end
        end
        if (found) begin
            clock_in(fo, fa, fb);
            check_eq("R7", {10'd0, flags_o[2:0]}, {10'd0, tgt});
        end else begin
            checks++; errors++;
            $display("FAIL R7: flag state %b unreachable, actual none expected found", tgt);
        end
    endtask

    initial begin
        int unary[7] = '{8, 9, 10, 11, 12, 13, 14};
        repeat (3) @(negedge clk_i);
        // R12: reset state
        check_eq("R12", {9'd0, flags_o}, 13'd0);
        rst_i = 1'b0;

        // R1 R2 R3 R4: binary ops under both carry states
        for (int cs = 0; cs < 2; cs++) begin
            if (cs == 0) begin clock_in(13, 0, 0); clock_in(12, 0, 0); end
            else clock_in(13, 0, 0);
            @(negedge clk_i);
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 5) begin
                    for (int op = 0; op < 8; op++) eval(op, a, b, tag_of(op));
                end
                eval(1, a, 255, "R1");
                eval(3, a, 255, "R2");
            end
        end

        // R5 R6 R7 R8 R9: unary ops under every N/H/C state
        for (int s = 0; s < 8; s++) begin
            load_nhc(3'(s));
            for (int a = 0; a < 256; a++) begin
                foreach (unary[k]) eval(unary[k], a, 8'h5A, tag_of(unary[k]));
                eval(15, a, 0, "R9");
            end
        end

        // R10: write request gated by wr_en_i
        wr_en_i = 1'b0;
        for (int op = 0; op < 16; op++) begin
            eval(op, 8'h3C, 8'h0F, "R10");
            checks++;
            if (acc_wr_o !== 1'b0) begin
                errors++;
                $display("FAIL R10: actual %b expected 0", acc_wr_o);
            end
        end
        wr_en_i = 1'b1;

        // R11: no load without strobe
        clock_in(13, 0, 0);
        @(negedge clk_i);
        op_i = 4'd12; acc_i = 8'h00;
        @(negedge clk_i);
        @(negedge clk_i);
        check_eq("R11", {9'd0, flags_o}, {9'd0, cur_fl});

        // R12: reset wins over strobe
        @(negedge clk_i);
        rst_i = 1'b1; flag_we_i = 1'b1; op_i = 4'd13;
        @(negedge clk_i);
        rst_i = 1'b0; flag_we_i = 1'b0;
        cur_fl = 4'b0000;
        check_eq("R12", {9'd0, flags_o}, 13'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule